// File: doc/BRIEF.md
# Bursty Pseudo-Random Byte Source

This block is a stimulus source for testing data integrity on a streaming link. It sends a byte stream over a valid/ready handshake. The bytes come from a 32-bit linear feedback shift register, so a receiver that holds the same seed can rebuild every byte and compare. A second 16-bit shift register, separate from the first, sets how long each packet is and how many idle cycles come between packets. The result is a stream with packets of many sizes and starts and stops that do not repeat on a fixed period. This kind of stream shows up flow-control and end-of-packet faults that a steady fixed-rate stream would not reach.

Both seeds are inputs and are loaded while reset is held. A zero seed would lock a shift register at zero, so it is replaced with a fixed nonzero constant. The enable input can pause the stream at any byte boundary. Pausing does not change the shift register state, so the sequence and the current packet carry on from the same point when enable returns.

Top module: `lbt_traffic_gen`

## Requirements
- R1: While `rst_n` is low, `tx_valid` is 0. In the first cycle after reset is released, `tx_valid` is still 0. The first byte sent after reset is the low 8 bits of the loaded data seed.
- R2: The data register is a 32-bit Galois LFSR that shifts right. On each step the new state is `state >> 1`, XORed with mask 32'h8020_0003 when the old bit 0 was 1 (polynomial x^32+x^22+x^2+x+1). `tx_data` is state bits [7:0]. The register steps exactly once for each accepted byte (`tx_valid && tx_ready`) and at no other time.
- R3: On reset, a zero data seed loads 32'h1D2C_3B4A and a zero control seed loads 16'hB5A3. A nonzero seed loads unchanged. Neither register ever holds zero.
- R4: The control register is a 16-bit right-shifting Galois LFSR with mask 16'hB400. At the start of each packet, the length is drawn as 1 + control[8:0] (1 to 512 bytes) and the register steps once.
- R5: `tx_last` is 1 together with the final byte of each packet and only then. It is never 1 while `tx_valid` is 0.
- R6: When the last byte of a packet is accepted, the gap g = control[3:0] is drawn and the control register steps once. If enable stays high, `tx_valid` is then low for exactly g+1 cycles before the next packet begins. The gap counter does not count while enable is low.
- R7: Once `tx_valid` is 1, it stays 1 until the byte is accepted. `tx_data` and `tx_last` hold steady during that time.
- R8: If enable is low in the cycle a byte is accepted, `tx_valid` is 0 in the next cycle. It stays 0 while enable is low. When enable returns, the stream continues with the next byte of the same packet and the same sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; seeds load while it is low |
| enable | input | 1 | Lets the stream run; sampled at byte boundaries |
| data_seed | input | 32 | Seed for the payload LFSR |
| ctrl_seed | input | 16 | Seed for the length and gap LFSR |
| tx_data | output | 8 | Payload byte |
| tx_valid | output | 1 | Byte on `tx_data` is valid |
| tx_ready | input | 1 | Sink accepts the byte this cycle |
| tx_last | output | 1 | Marks the final byte of a packet |

## Verification
The bench targets packets of the shortest and longest length, zero seeds, and long back-pressure stalls. A design that steps the data register on a stalled cycle would skip bytes. A design that reads the gap and the length in the wrong order would shift every later packet boundary. The bench also turns enable off at random points, including on the last byte of a packet. A design that drops valid in the middle of a handshake, or that loses its count of remaining bytes during a pause, would send a packet that is too short or too long. The bench measures the idle time between packets against the gap drawn for each one, which catches off-by-one errors in the gap counter.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

  typedef enum logic [1:0] {
    ST_PICK  = 2'd0,
    ST_SEND  = 2'd1,
    ST_PAUSE = 2'd2,
    ST_GAP   = 2'd3
  } burst_st_e;

  localparam logic [31:0] DATA_MASK_DEF     = 32'h8020_0003;
  localparam logic [31:0] DATA_FALLBACK_DEF = 32'h1D2C_3B4A;
  localparam logic [15:0] CTRL_MASK_DEF     = 16'hB400;
  localparam logic [15:0] CTRL_FALLBACK_DEF = 16'hB5A3;

  // Packet length from a control field: one plus the low 'bits' bits.
  function automatic logic [15:0] pkt_len16(logic [15:0] field, int unsigned bits);
    logic [15:0] keep;
    keep = (16'd1 << bits) - 16'd1;
    return (field & keep) + 16'd1;
  endfunction

  // Idle gap from a control field: the low 'bits' bits.
  function automatic logic [15:0] gap_len16(logic [15:0] field, int unsigned bits);
    logic [15:0] keep;
    keep = (16'd1 << bits) - 16'd1;
    return field & keep;
  endfunction

endpackage

// File: rtl/lbt_galois_lfsr.sv
module lbt_galois_lfsr #(
  parameter int unsigned W        = 32,
  parameter logic [W-1:0] MASK    = '1,
  parameter logic [W-1:0] FALLBACK = 'd1,
  parameter int unsigned OUT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     seed,
  input  logic             advance,
  output logic [OUT_W-1:0] low_bits
);

  logic [W-1:0] state;
  logic [W-1:0] state_next;
  logic         seed_is_zero;

  function automatic logic [W-1:0] galois_step(logic [W-1:0] s);
    logic [W-1:0] shifted;
    shifted = s >> 1;
    return s[0] ? (shifted ^ MASK) : shifted;
  endfunction

  assign seed_is_zero = (seed == '0);
  assign state_next   = galois_step(state);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= seed_is_zero ? FALLBACK : seed;
    end else if (advance) begin
      state <= state_next;
    end
  end

  assign low_bits = state[OUT_W-1:0];

  // R3: the register never locks at zero
  p_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  // R2: no step without an advance request
  p_step_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(state));

  // R2: an advance always moves the state
  p_step_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (state != $past(state)));

endmodule

// File: rtl/lbt_burst_fsm.sv
module lbt_burst_fsm
  import lbt_pkg::*;
#(
  parameter int unsigned LEN_BITS = 9,
  parameter int unsigned GAP_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [LEN_BITS-1:0] ctrl_field,
  input  logic                tx_ready,
  output logic                tx_valid,
  output logic                tx_last,
  output logic                accept,
  output logic                ctrl_step
);

  localparam int unsigned REM_W = LEN_BITS + 1;
  localparam int unsigned GCW   = GAP_BITS;

  burst_st_e        st;
  logic [REM_W-1:0] remaining;
  logic [GCW-1:0]   gap_cnt;

  logic             draw_len;
  logic             draw_gap;
  logic             final_byte;
  logic [REM_W-1:0] new_len;
  logic [GCW-1:0]   new_gap;

  assign new_len    = REM_W'(pkt_len16(16'(ctrl_field), LEN_BITS));
  assign new_gap    = GCW'(gap_len16(16'(ctrl_field), GAP_BITS));

  assign tx_valid   = (st == ST_SEND);
  assign final_byte = (remaining == REM_W'(1));
  assign tx_last    = tx_valid && final_byte;
  assign accept     = tx_valid && tx_ready;
  assign draw_len   = (st == ST_PICK) && enable;
  assign draw_gap   = accept && final_byte;
  assign ctrl_step  = draw_len || draw_gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_PICK;
      remaining <= '0;
      gap_cnt   <= '0;
    end else begin
      unique case (st)
        ST_PICK: begin
          if (draw_len) begin
            remaining <= new_len;
            st        <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (draw_gap) begin
            remaining <= '0;
            gap_cnt   <= new_gap;
            st        <= (new_gap == '0) ? ST_PICK : ST_GAP;
          end else if (accept) begin
            remaining <= remaining - REM_W'(1);
            st        <= enable ? ST_SEND : ST_PAUSE;
          end
        end
        ST_PAUSE: begin
          if (enable) st <= ST_SEND;
        end
        ST_GAP: begin
          if (enable) begin
            gap_cnt <= gap_cnt - GCW'(1);
            if (gap_cnt == GCW'(1)) st <= ST_PICK;
          end
        end
        default: st <= ST_PICK;
      endcase
    end
  end

  // R5: the end marker only travels with a valid byte
  p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  // R7: an offered byte stays offered, marker unchanged
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_last)));

  // R8: disabled at a byte boundary means valid drops next cycle
  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !enable) |=> !tx_valid);

  // R8: no new byte appears while disabled
  p_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && !enable) |=> !tx_valid);

  // R4: a packet in flight always has bytes left
  p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SEND) |-> (remaining != '0));

  // R6: the gap state always has cycles left to wait
  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP) |-> (gap_cnt != '0));

  // R6: the gap holds while disabled
  p_gap_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_GAP) && !enable) |=> ((st == ST_GAP) && $stable(gap_cnt)));

  // R4: exactly one draw at a time
  p_one_draw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(draw_len && draw_gap));

endmodule

// File: rtl/lbt_traffic_gen.sv
module lbt_traffic_gen
  import lbt_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CTRL_W   = 16,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned LEN_BITS = 9,
  parameter int unsigned GAP_BITS = 4,
  parameter logic [DATA_W-1:0] DATA_MASK     = DATA_W'(DATA_MASK_DEF),
  parameter logic [DATA_W-1:0] DATA_FALLBACK = DATA_W'(DATA_FALLBACK_DEF),
  parameter logic [CTRL_W-1:0] CTRL_MASK     = CTRL_W'(CTRL_MASK_DEF),
  parameter logic [CTRL_W-1:0] CTRL_FALLBACK = CTRL_W'(CTRL_FALLBACK_DEF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DATA_W-1:0] data_seed,
  input  logic [CTRL_W-1:0] ctrl_seed,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last
);

  logic                accept;
  logic                ctrl_step;
  logic [LEN_BITS-1:0] ctrl_field;
  logic [BYTE_W-1:0]   data_byte;

  lbt_galois_lfsr #(
    .W        (DATA_W),
    .MASK     (DATA_MASK),
    .FALLBACK (DATA_FALLBACK),
    .OUT_W    (BYTE_W)
  ) u_data_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed     (data_seed),
    .advance  (accept),
    .low_bits (data_byte)
  );

  lbt_galois_lfsr #(
    .W        (CTRL_W),
    .MASK     (CTRL_MASK),
    .FALLBACK (CTRL_FALLBACK),
    .OUT_W    (LEN_BITS)
  ) u_ctrl_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed     (ctrl_seed),
    .advance  (ctrl_step),
    .low_bits (ctrl_field)
  );

  lbt_burst_fsm #(
    .LEN_BITS (LEN_BITS),
    .GAP_BITS (GAP_BITS)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .ctrl_field (ctrl_field),
    .tx_ready   (tx_ready),
    .tx_valid   (tx_valid),
    .tx_last    (tx_last),
    .accept     (accept),
    .ctrl_step  (ctrl_step)
  );

  assign tx_data = data_byte;

  // R7: payload is steady while the sink stalls
  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> $stable(tx_data));

  // R2: payload changes only through an accepted byte
  p_data_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(tx_data));

endmodule

// File: tb/lbt_traffic_gen_tb.sv
module lbt_traffic_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] data_seed = '0;
  logic [15:0] ctrl_seed = '0;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic        tx_last;

  always #2 clk = ~clk;

  lbt_traffic_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .data_seed (data_seed),
    .ctrl_seed (ctrl_seed),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_last   (tx_last)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
    end
  endtask

  // Bench model of the two shift registers, written from the requirements
  logic [31:0] m_data;
  logic [15:0] m_ctrl;

  function automatic logic [31:0] adv32(logic [31:0] s);
    logic [31:0] r;
    r = {1'b0, s[31:1]};
    if (s[0]) r = r ^ 32'h8020_0003;
    return r;
  endfunction

  function automatic logic [15:0] adv16(logic [15:0] s);
    logic [15:0] r;
    r = {1'b0, s[15:1]};
    if (s[0]) r = r ^ 16'hB400;
    return r;
  endfunction

  logic [8:0] exp_q[$];   // {last, byte}
  int         gap_q[$];

  // Driver: pushes one full expected packet plus its following gap
  task automatic push_packet();
    int len;
    len = int'(m_ctrl[8:0]) + 1;
    m_ctrl = adv16(m_ctrl);
    for (int i = 0; i < len; i++) begin
      exp_q.push_back({(i == len - 1), m_data[7:0]});
      m_data = adv32(m_data);
    end
    gap_q.push_back(int'(m_ctrl[3:0]));
    m_ctrl = adv16(m_ctrl);
  endtask

  string data_tag = "R2";
  int    ready_mode = 0;   // 0: always ready, 1: random
  int    en_mode = 0;      // 0: held high, 1: random toggling
  int    pkt_count = 0;
  int    first_len = 0;
  int    cur_len = 0;
  bit    want_first = 1'b0;

  // Input driver, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (ready_mode == 0) tx_ready <= 1'b1;
    else tx_ready <= ($urandom_range(0, 9) < 7);
    if (rst_n) begin
      if (en_mode == 0) enable <= 1'b1;
      else if ($urandom_range(0, 15) == 0) enable <= ~enable;
    end
  end

  // Monitor and scoreboard, sampling on the falling edge
  bit       prev_valid, prev_ready, prev_en, prev_acc, prev_last;
  bit [7:0] prev_data;
  bit       gap_armed, gap_en_ok;
  int       idle;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_valid = 0; prev_ready = 0; prev_en = 0; prev_acc = 0; prev_last = 0;
      prev_data = '0; gap_armed = 0; gap_en_ok = 0; idle = 0; cur_len = 0;
    end else begin
      if (prev_valid && !prev_ready)
        check(tx_valid && tx_data == prev_data && tx_last == prev_last,
              "R7 hold", int'({tx_valid, tx_last, tx_data}),
              int'({1'b1, prev_last, prev_data}));
      if (prev_acc && !prev_en)
        check(!tx_valid, "R8 stop", int'(tx_valid), 0);
      if (tx_valid && !prev_valid && gap_armed) begin
        int g;
        g = (gap_q.size() > 0) ? gap_q.pop_front() : -1;
        if (gap_en_ok) check(idle == g + 1, "R6 gap", idle, g + 1);
        gap_armed = 0;
      end
      if (!tx_valid) begin
        idle++;
        if (!enable) gap_en_ok = 0;
      end
      if (tx_tx_accept()) begin
        logic [8:0] it;
        if (exp_q.size() == 0) push_packet();
        it = exp_q.pop_front();
        check(tx_data == it[7:0], data_tag, int'(tx_data), int'(it[7:0]));
        check(tx_last == it[8], "R4 R5 last", int'(tx_last), int'(it[8]));
        cur_len++;
        if (tx_last) begin
          if (want_first) begin first_len = cur_len; want_first = 0; end
          cur_len = 0;
          pkt_count++;
          gap_armed = 1;
          gap_en_ok = 1;
          idle = 0;
        end
      end
      prev_valid = tx_valid; prev_ready = tx_ready; prev_en = enable;
      prev_acc = tx_valid && tx_ready; prev_last = tx_last; prev_data = tx_data;
    end
  end

  function automatic bit tx_tx_accept();
    return tx_valid && tx_ready;
  endfunction

  task automatic do_reset(input logic [31:0] ds, input logic [15:0] cs);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    data_seed = ds;
    ctrl_seed = cs;
    repeat (3) @(posedge clk);
    m_data = (ds == 0) ? 32'h1D2C_3B4A : ds;
    m_ctrl = (cs == 0) ? 16'hB5A3 : cs;
    exp_q.delete();
    gap_q.delete();
    pkt_count = 0;
    want_first = 1'b1;
    @(negedge clk);
    check(!tx_valid, "R1 valid in reset", int'(tx_valid), 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!tx_valid, "R1 first cycle", int'(tx_valid), 0);
  endtask

  task automatic run_packets(input int n);
    int guard;
    guard = 0;
    while (pkt_count < n && guard < 60000) begin
      @(posedge clk);
      guard++;
    end
    check(pkt_count >= n, "progress", pkt_count, n);
  endtask

  bit done = 1'b0;

  initial begin
    // Phase A: first length forced to 1, random back-pressure
    ready_mode = 1; en_mode = 0; data_tag = "R1 R2";
    do_reset(32'h1234_5678, 16'h8E00);
    run_packets(30);
    check(first_len == 1, "R4 min length", first_len, 1);
    // Phase B: enable toggled at random
    en_mode = 1; data_tag = "R8 R2";
    run_packets(60);
    // Phase C: zero seeds substitute the fallback values
    en_mode = 0; ready_mode = 0; data_tag = "R3";
    do_reset(32'h0, 16'h0);
    run_packets(10);
    check(first_len == 420, "R3 R4 fallback length", first_len, 420);
    // Phase D: first length forced to the maximum
    ready_mode = 1; en_mode = 1; data_tag = "R2";
    do_reset(32'hDEAD_BEEF, 16'h41FF);
    run_packets(6);
    check(first_len == 512, "R4 max length", first_len, 512);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", pkt_count, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule